// File: doc/BRIEF.md
# Range Write-Protection Controller

This block is the permission keeper of a serial memory organised as 16-bit words. Each decoded instruction from the serial front end arrives as a one-cycle strobe. The strobe carries a 2-bit opcode, an address field, and the sampled levels of the protect-select pin (`ins_pre`) and the program-enable pin (`ins_pe`). The controller then decides whether the instruction may go ahead: a single-word write, a bulk write of every word, or an update of the protect register. The array itself, the shift registers and the program timer are outside this block. They act only on the permit pulses this block raises.

Protection is a boundary. Every word whose address is equal to or above the stored protect address is refused. A "cleared" flag sits beside that address. When the flag is set, the register holds all ones but protects nothing. Changes to the protect register need two instructions: an arming instruction, then the update itself. A one-time lock freezes the protect register for good. The synchronous reset stands for power-up, and it also releases the lock, because no non-volatile storage is modelled.

Top module: `wprot_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, write-enable is off, `prot_addr` reads all ones, the register is in the cleared state, nothing is armed and nothing is locked. Reset also releases a lock set earlier.
- R2: Instruction encodings with `ins_pre` low:
  - Opcode 2'b00 with the two top address bits 2'b11 sets write-enable.
  - Opcode 2'b00 with the two top address bits 2'b00 clears write-enable.
  - Opcode 2'b10 is a read. It never changes the write-enable state.
  - While write-enable is off, no word-write or write-all permit is given.
- R3: A word write (opcode 2'b01, `ins_pre` low) raises `wr_ok` only when all of these hold:
  - write-enable is on;
  - `ins_pe` is high;
  - either the register is cleared, or `ins_addr` is below `prot_addr`.
- R4: An arming instruction (opcode 2'b00, top address bits 2'b11, `ins_pre` high) arms the protect register only if write-enable is on and `ins_pe` is high.
- R5: The armed state lasts for exactly the next strobe. Any other instruction in between, including a read, disarms it.
- R6: A protect clear (opcode 2'b11, address all ones, `ins_pre` and `ins_pe` high) right after arming raises `preg_ok`. It loads all ones and sets the cleared state. From then on the top word can be written and write-all is permitted.
- R7: A protect write (opcode 2'b01, `ins_pre` and `ins_pe` high) right after arming is honoured only in the cleared state. It loads `ins_addr` and leaves the cleared state. A loaded value of all ones therefore protects the top word.
- R8: Write-all (opcode 2'b00, top address bits 2'b01, `ins_pre` low) raises `wall_ok` only in the cleared state, with write-enable on and `ins_pe` high.
- R9: A lock (opcode 2'b00, address all zeros, `ins_pre` and `ins_pe` high) right after arming raises `preg_ok`. After it, no instruction raises `preg_ok` or changes `prot_addr` until reset.
- R10: With `ins_pre` low, the protect-register opcodes act as array instructions and never raise `preg_ok`.
- R11: The permits are combinational pulses in the cycle of the strobe. They stay low without a strobe, and at most one of them is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, models power-up |
| ins_vld | input | 1 | Decoded-instruction strobe, one cycle |
| ins_op | input | 2 | Instruction opcode |
| ins_addr | input | AW | Instruction address field |
| ins_pre | input | 1 | Sampled protect-select pin level |
| ins_pe | input | 1 | Sampled program-enable pin level |
| wr_ok | output | 1 | Word-write permit pulse |
| wall_ok | output | 1 | Write-all permit pulse |
| preg_ok | output | 1 | Protect-register update permit pulse |
| prot_addr | output | AW | Stored protect address for readback |

## Verification
The hardest state to reach is a locked protect register that holds a real boundary. Getting there takes a fixed chain of instructions:
1. set write-enable;
2. arm, then clear;
3. arm again, then write the boundary;
4. arm a third time, then lock.

Each step must arrive with the right pin levels and with nothing between the arming and the update. The stimulus issues that chain back-to-back. It then tries every protect update and confirms that the boundary still filters word writes. It also places a read and a mis-pinned arming instruction inside otherwise valid pairs, to show that those pairs are refused.

// File: rtl/wprot_ctrl.sv
module wprot_ctrl #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ins_vld,
  input  logic [1:0]    ins_op,
  input  logic [AW-1:0] ins_addr,
  input  logic          ins_pre,
  input  logic          ins_pe,
  output logic          wr_ok,
  output logic          wall_ok,
  output logic          preg_ok,
  output logic [AW-1:0] prot_addr
);
  localparam logic [AW-1:0] ONES = '1;

  logic          wen_q, arm_q, clr_q, lock_q;
  logic [AW-1:0] pa_q;

  logic [1:0] sub;
  logic ext, c_wen, c_wds, c_wall, c_wr, c_pren, c_plock, c_pwr, c_pclr, upd_ok;

  assign sub     = ins_addr[AW-1:AW-2];
  assign ext     = ins_vld && ins_op == 2'b00;
  assign c_wen   = ext && !ins_pre && sub == 2'b11;
  assign c_wds   = ext && !ins_pre && sub == 2'b00;
  assign c_wall  = ext && !ins_pre && sub == 2'b01;
  assign c_wr    = ins_vld && ins_op == 2'b01 && !ins_pre;
  assign c_pren  = ext && ins_pre && sub == 2'b11;
  assign c_plock = ext && ins_pre && ins_addr == '0;
  assign c_pwr   = ins_vld && ins_op == 2'b01 && ins_pre;
  assign c_pclr  = ins_vld && ins_op == 2'b11 && ins_pre && ins_addr == ONES;

  assign upd_ok    = arm_q && ins_pe && !lock_q;
  assign preg_ok   = upd_ok && (c_pclr || c_plock || (c_pwr && clr_q));
  assign wr_ok     = c_wr && wen_q && ins_pe && (clr_q || ins_addr < pa_q);
  assign wall_ok   = c_wall && wen_q && ins_pe && clr_q;
  assign prot_addr = pa_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wen_q  <= 1'b0;
      arm_q  <= 1'b0;
      clr_q  <= 1'b1;
      lock_q <= 1'b0;
      pa_q   <= ONES;
    end else if (ins_vld) begin
      arm_q <= c_pren && wen_q && ins_pe;
      if (c_wen) wen_q <= 1'b1;
      if (c_wds) wen_q <= 1'b0;
      if (preg_ok) begin
        if (c_pclr) begin
          pa_q  <= ONES;
          clr_q <= 1'b1;
        end
        if (c_pwr) begin
          pa_q  <= ins_addr;
          clr_q <= 1'b0;
        end
        if (c_plock) lock_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wprot_ctrl_chk.sv
module wprot_ctrl_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          ins_vld,
  input logic [AW-1:0] ins_addr,
  input logic          wr_ok,
  input logic          wall_ok,
  input logic          preg_ok,
  input logic [AW-1:0] prot_addr,
  input logic          wen_q,
  input logic          arm_q,
  input logic          lock_q
);
  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (!wen_q && !lock_q && !arm_q && (&prot_addr))); // R1
  AST_PROGRAM_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst) (wr_ok || wall_ok) |-> wen_q); // R2
  AST_WRITE_BELOW_BOUND: assert property (@(posedge clk) disable iff (rst) (wr_ok && !(&prot_addr)) |-> (ins_addr < prot_addr)); // R3
  AST_UPDATE_ARMED: assert property (@(posedge clk) disable iff (rst) preg_ok |-> arm_q); // R5
  AST_WALL_UNPROTECTED: assert property (@(posedge clk) disable iff (rst) wall_ok |-> (&prot_addr)); // R8
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (rst) lock_q |=> ($stable(prot_addr) && lock_q)); // R9
  AST_LOCK_NO_UPDATE: assert property (@(posedge clk) disable iff (rst) lock_q |-> !preg_ok); // R9
  AST_PULSE_WITH_STROBE: assert property (@(posedge clk) disable iff (rst) !ins_vld |-> !(wr_ok || wall_ok || preg_ok)); // R11
  AST_ONE_PERMIT: assert property (@(posedge clk) disable iff (rst) $onehot0({wr_ok, wall_ok, preg_ok})); // R11
endmodule

bind wprot_ctrl wprot_ctrl_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .ins_vld(ins_vld), .ins_addr(ins_addr),
  .wr_ok(wr_ok), .wall_ok(wall_ok), .preg_ok(preg_ok), .prot_addr(prot_addr),
  .wen_q(wen_q), .arm_q(arm_q), .lock_q(lock_q)
);

// File: tb/wprot_ctrl_test.sv
`timescale 1ns/1ps
module wprot_ctrl_test;
  logic clk = 0, rst = 1, ins_vld = 0, ins_pre = 0, ins_pe = 0;
  logic [1:0] ins_op = 0;
  logic [5:0] ins_addr = 0;
  logic wr_ok, wall_ok, preg_ok;
  logic [5:0] prot_addr;
  int n_run = 0, n_fail = 0;

  typedef struct { logic wr, wall, preg; logic [5:0] pa; string tag; } exp_t;
  exp_t sb[$];

  localparam logic [1:0] OX = 2'b00, OW = 2'b01, ORD = 2'b10, OC = 2'b11;
  localparam logic [5:0] A_EN = 6'b110000, A_ALL = 6'b010000, A_Z = 6'b000000, A_1 = 6'b111111;

  always #2 clk = ~clk;

  wprot_ctrl #(.AW(6)) uut (.*);

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ins_vld) begin
        if (sb.size() == 0) chk(0, "R11", "unexpected strobe", 1, 0);
        else begin
          exp_t e;
          e = sb.pop_front();
          chk(wr_ok === e.wr, e.tag, "wr_ok", wr_ok, e.wr);
          chk(wall_ok === e.wall, e.tag, "wall_ok", wall_ok, e.wall);
          chk(preg_ok === e.preg, e.tag, "preg_ok", preg_ok, e.preg);
          chk(prot_addr === e.pa, e.tag, "prot_addr", prot_addr, e.pa);
        end
      end else begin
        chk({wr_ok, wall_ok, preg_ok} === 3'b000, "R11", "permit without strobe", {wr_ok, wall_ok, preg_ok}, 0);
      end
    end
  end

  task automatic cmd(input logic [1:0] op, input logic [5:0] a, input logic pre, input logic pe,
                     input logic ewr, input logic ewall, input logic epreg, input logic [5:0] epa, input string tag);
    exp_t e;
    e.wr = ewr; e.wall = ewall; e.preg = epreg; e.pa = epa; e.tag = tag;
    @(posedge clk); #1;
    sb.push_back(e);
    ins_vld = 1; ins_op = op; ins_addr = a; ins_pre = pre; ins_pe = pe;
  endtask

  task automatic idle();
    @(posedge clk); #1;
    ins_vld = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    ins_vld = 0; rst = 1;
    @(posedge clk); #1;
    @(negedge clk);
    chk(prot_addr === A_1, "R1", "prot_addr in reset", prot_addr, A_1);
    chk({wr_ok, wall_ok, preg_ok} === 3'b000, "R1", "permits in reset", {wr_ok, wall_ok, preg_ok}, 0);
    @(posedge clk); #1;
    rst = 0;
  endtask

  initial begin
    #80000;
    chk(0, "WDOG", "watchdog expired", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R2: disabled after power-up
    cmd(OW, 6'd5, 0, 1, 0, 0, 0, A_1, "R2");
    cmd(OX, A_ALL, 0, 1, 0, 0, 0, A_1, "R2");
    // R4: arming without write-enable fails
    cmd(OX, A_EN, 1, 1, 0, 0, 0, A_1, "R4");
    cmd(OC, A_1, 1, 1, 0, 0, 0, A_1, "R4");
    cmd(OX, A_EN, 0, 1, 0, 0, 0, A_1, "R2");
    cmd(ORD, 6'd3, 0, 0, 0, 0, 0, A_1, "R2");
    cmd(OW, A_1, 0, 1, 1, 0, 0, A_1, "R1");
    cmd(OW, 6'd10, 0, 0, 0, 0, 0, A_1, "R3");
    cmd(OX, A_ALL, 0, 1, 0, 1, 0, A_1, "R8");
    // R4: pe low on arming
    cmd(OX, A_EN, 1, 0, 0, 0, 0, A_1, "R4");
    cmd(OC, A_1, 1, 1, 0, 0, 0, A_1, "R4");
    // R5: read in between disarms
    cmd(OX, A_EN, 1, 1, 0, 0, 0, A_1, "R5");
    cmd(ORD, 6'd0, 0, 0, 0, 0, 0, A_1, "R5");
    cmd(OC, A_1, 1, 1, 0, 0, 0, A_1, "R5");
    // R7: boundary 20
    cmd(OX, A_EN, 1, 1, 0, 0, 0, A_1, "R7");
    cmd(OW, 6'd20, 1, 1, 0, 0, 1, A_1, "R7");
    cmd(OW, 6'd19, 0, 1, 1, 0, 0, 6'd20, "R3");
    cmd(OW, 6'd20, 0, 1, 0, 0, 0, 6'd20, "R3");
    cmd(OW, 6'd40, 0, 1, 0, 0, 0, 6'd20, "R3");
    cmd(OX, A_ALL, 0, 1, 0, 0, 0, 6'd20, "R8");
    cmd(OX, A_EN, 1, 1, 0, 0, 0, 6'd20, "R7");
    cmd(OW, 6'd30, 1, 1, 0, 0, 0, 6'd20, "R7");
    // R6: clear
    cmd(OX, A_EN, 1, 1, 0, 0, 0, 6'd20, "R6");
    cmd(OC, A_1, 1, 1, 0, 0, 1, 6'd20, "R6");
    cmd(OW, A_1, 0, 1, 1, 0, 0, A_1, "R6");
    cmd(OX, A_ALL, 0, 1, 0, 1, 0, A_1, "R6");
    // R7: all ones written protects top word
    cmd(OX, A_EN, 1, 1, 0, 0, 0, A_1, "R7");
    cmd(OW, A_1, 1, 1, 0, 0, 1, A_1, "R7");
    cmd(OW, A_1, 0, 1, 0, 0, 0, A_1, "R7");
    cmd(OW, 6'd62, 0, 1, 1, 0, 0, A_1, "R7");
    cmd(OX, A_ALL, 0, 1, 0, 0, 0, A_1, "R7");
    // R10: pre low after arming acts on array
    cmd(OX, A_EN, 1, 1, 0, 0, 0, A_1, "R10");
    cmd(OW, 6'd5, 0, 1, 1, 0, 0, A_1, "R10");
    cmd(OC, A_1, 0, 1, 0, 0, 0, A_1, "R10");
    // R9: lock with boundary 40
    cmd(OX, A_EN, 1, 1, 0, 0, 0, A_1, "R9");
    cmd(OC, A_1, 1, 1, 0, 0, 1, A_1, "R9");
    cmd(OX, A_EN, 1, 1, 0, 0, 0, A_1, "R9");
    cmd(OW, 6'd40, 1, 1, 0, 0, 1, A_1, "R9");
    cmd(OX, A_EN, 1, 1, 0, 0, 0, 6'd40, "R9");
    cmd(OX, A_Z, 1, 1, 0, 0, 1, 6'd40, "R9");
    cmd(OX, A_EN, 1, 1, 0, 0, 0, 6'd40, "R9");
    cmd(OC, A_1, 1, 1, 0, 0, 0, 6'd40, "R9");
    cmd(OX, A_EN, 1, 1, 0, 0, 0, 6'd40, "R9");
    cmd(OW, 6'd10, 1, 1, 0, 0, 0, 6'd40, "R9");
    cmd(OW, 6'd39, 0, 1, 1, 0, 0, 6'd40, "R9");
    cmd(OW, 6'd40, 0, 1, 0, 0, 0, 6'd40, "R9");
    // R2: disable
    cmd(OX, A_Z, 0, 1, 0, 0, 0, 6'd40, "R2");
    cmd(OW, 6'd2, 0, 1, 0, 0, 0, 6'd40, "R2");
    idle();
    idle();
    // R1: reset releases the lock
    do_reset();
    cmd(OX, A_EN, 0, 1, 0, 0, 0, A_1, "R1");
    cmd(OX, A_EN, 1, 1, 0, 0, 0, A_1, "R1");
    cmd(OC, A_1, 1, 1, 0, 0, 1, A_1, "R1");
    idle();
    idle();
    chk(sb.size() == 0, "R11", "pending expectations", sb.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule